// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles a control transfer in one registered step. For each instruction marked valid, it decides whether the transfer is taken and whether the instruction in the delay slot must be squashed. It also computes the address two slots ahead, called the next-next PC. The instruction class selects which condition source is used:

- integer condition flags, through a 4-bit condition code;
- a 64-bit register value compared against zero;
- an unconditional subroutine call, which also asks for a link write.

The flag register carries two sets of flags. The low nibble holds the 32-bit set and the high nibble holds the 64-bit set. Only the predicted-branch class may choose between them, through a select bit. Each of the four classes builds its displacement from the raw displacement input in its own way. When the transfer is not taken, the target output is PC+8, so the result is always defined.

The decision appears on the outputs one clock after the instruction is presented. The valid output marks that cycle. Floating-point conditions, instruction decode and pipeline flushing are handled outside this unit.

Top module: `branch_resolve`

## Requirements
- R1: Flag nibbles are laid out N=bit3, Z=bit2, V=bit1, C=bit0. Condition codes: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V. Codes 8 to 15 are the inverses of codes 0 to 7 (8 is always, 9 !Z, 10 !(Z|(N^V)), 11 !(N^V), 12 !(C|Z), 13 !C, 14 !N, 15 !V). The short class (kind 0) always uses flags 3:0.
- R2: The predicted class (kind 1) uses flags 7:4 when cc_sel is 1 and flags 3:0 when cc_sel is 0. For kind 0, cc_sel has no effect.
- R3: The taken target is PC plus a displacement shifted left by 2. For kind 0 the displacement is disp_in[21:0], sign-extended. For kind 1 it is disp_in[18:0], sign-extended.
- R4: The register class (kind 2) tests src_val as a signed value against zero, using cond_in[2:0]: 1 ==, 2 <=, 3 <, 5 !=, 6 >, 7 >=. Codes 0 and 4 are never taken, and cond_in[3] is ignored. The taken target is PC + ((sign-extended disp_in[15:14]) << 16 | disp_in[13:0] << 2).
- R5: A conditional transfer (kind 0 or 1 with code not 0 or 8, or any kind 2) annuls the delay slot only when it is not taken and annul_bit is 1. A taken conditional transfer never annuls.
- R6: Code 8 (kinds 0 and 1) is always taken, and code 0 is never taken. In both cases the annul output equals annul_bit.
- R7: The call class (kind 3) is always taken, with target PC + (sign-extended disp_in[29:0] << 2), link_out = 1 and annul_out = 0. For kinds 0 to 2, link_out is 0.
- R8: When the transfer is not taken, target_out is PC+8.
- R9: The results for an instruction presented with valid_in high appear on the outputs after the next rising edge, with valid_out high. A cycle with valid_in low yields valid_out, taken_out, annul_out and link_out all 0 after the next edge.
- R10: While rst_n is low, valid_out, taken_out, annul_out, link_out and target_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Inputs carry an instruction this cycle |
| kind_in | input | 2 | Class: 0 short, 1 predicted, 2 register, 3 call |
| cond_in | input | 4 | Condition code (flag or register test) |
| ccr_in | input | 8 | Flags: 7:4 64-bit set, 3:0 32-bit set |
| src_val | input | 64 | Register value for the zero test |
| disp_in | input | 30 | Raw displacement field |
| annul_bit | input | 1 | Annul request from the instruction |
| cc_sel | input | 1 | Flag set select for the predicted class |
| pc_in | input | 64 | Address of the transfer instruction |
| valid_out | output | 1 | Registered decision is present |
| taken_out | output | 1 | Transfer taken |
| annul_out | output | 1 | Delay slot squashed |
| link_out | output | 1 | Request to write PC to register 15 |
| target_out | output | 64 | Next-next PC |

## Verification
A wrong condition decode or nibble choice shows as an incorrect taken_out one cycle after the instruction is presented. Because a not-taken result forces the target to PC+8, the same error also shows on target_out. A wrong displacement extraction or sign extension changes target_out only when the transfer is taken, so the vectors include negative displacements for every class. The annul logic is checked against the annul bit for taken, untaken, always and never cases, because an annul error would hide behind a correct taken_out.

// File: rtl/bru_pkg.sv
package bru_pkg;
    typedef enum logic [1:0] {
        BK_SHORT = 2'd0,
        BK_PRED  = 2'd1,
        BK_REG   = 2'd2,
        BK_CALL  = 2'd3
    } bkind_e;

    localparam int SHORT_DW = 22;
    localparam int PRED_DW  = 19;
    localparam int CALL_DW  = 30;
    localparam int REG_HI_W = 2;
    localparam int REG_LO_W = 14;
endpackage

// File: rtl/bru_flag_cond.sv
// Evaluates one condition code against one flag nibble (R1).
module bru_flag_cond (
    input  logic [3:0] nzvc,
    input  logic [3:0] code,
    output logic       hit
);
    logic n, z, v, c, base;
    assign n = nzvc[3];
    assign z = nzvc[2];
    assign v = nzvc[1];
    assign c = nzvc[0];

    always_comb begin
        case (code[2:0])
            3'd0:    base = 1'b0;
            3'd1:    base = z;
            3'd2:    base = z | (n ^ v);
            3'd3:    base = n ^ v;
            3'd4:    base = c | z;
            3'd5:    base = c;
            3'd6:    base = n;
            default: base = v;
        endcase
        hit = base ^ code[3];
    end
endmodule

// File: rtl/bru_zero_test.sv
// Signed comparison of a register against zero (R4).
module bru_zero_test #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] value,
    input  logic [2:0]        code,
    output logic              hit
);
    logic is_zero, is_neg;
    assign is_zero = (value == '0);
    assign is_neg  = value[DATA_W-1];

    always_comb begin
        case (code)
            3'd1:    hit = is_zero;
            3'd2:    hit = is_zero | is_neg;
            3'd3:    hit = is_neg;
            3'd5:    hit = !is_zero;
            3'd6:    hit = !is_zero && !is_neg;
            3'd7:    hit = !is_neg;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
// Builds the taken target from the class-specific displacement (R3, R4, R7).
module bru_target
    import bru_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  bkind_e                kind,
    input  logic [CALL_DW-1:0]    disp,
    input  logic [ADDR_W-1:0]     pc,
    output logic [ADDR_W-1:0]     target
);
    localparam int REG_LO_POS = 2;
    localparam int REG_HI_POS = REG_LO_POS + REG_LO_W;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        case (kind)
            BK_SHORT: offset = ADDR_W'($signed(disp[SHORT_DW-1:0])) << 2;
            BK_PRED:  offset = ADDR_W'($signed(disp[PRED_DW-1:0])) << 2;
            BK_REG:   offset = (ADDR_W'($signed(disp[REG_LO_W +: REG_HI_W])) << REG_HI_POS)
                             | (ADDR_W'(disp[REG_LO_W-1:0]) << REG_LO_POS);
            default:  offset = ADDR_W'($signed(disp)) << 2;
        endcase
        target = pc + offset;
    end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import bru_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [1:0]          kind_in,
    input  logic [3:0]          cond_in,
    input  logic [7:0]          ccr_in,
    input  logic [DATA_W-1:0]   src_val,
    input  logic [CALL_DW-1:0]  disp_in,
    input  logic                annul_bit,
    input  logic                cc_sel,
    input  logic [ADDR_W-1:0]   pc_in,
    output logic                valid_out,
    output logic                taken_out,
    output logic                annul_out,
    output logic                link_out,
    output logic [ADDR_W-1:0]   target_out
);
    localparam logic [ADDR_W-1:0] SEQ_STEP = ADDR_W'(8);

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic              annul;
        logic              link;
        logic [ADDR_W-1:0] target;
    } result_t;

    result_t res_d, res_q;
    bkind_e  kind;
    logic [3:0] nibble;
    logic flag_hit, zero_hit;
    logic [ADDR_W-1:0] jump_addr;

    assign kind   = bkind_e'(kind_in);
    assign nibble = (kind == BK_PRED && cc_sel) ? ccr_in[7:4] : ccr_in[3:0];

    bru_flag_cond u_flag (
        .nzvc (nibble),
        .code (cond_in),
        .hit  (flag_hit)
    );

    bru_zero_test #(.DATA_W(DATA_W)) u_zero (
        .value (src_val),
        .code  (cond_in[2:0]),
        .hit   (zero_hit)
    );

    bru_target #(.ADDR_W(ADDR_W)) u_tgt (
        .kind   (kind),
        .disp   (disp_in),
        .pc     (pc_in),
        .target (jump_addr)
    );

    always_comb begin
        logic hit, uncond;
        res_d  = '0;
        hit    = 1'b0;
        uncond = 1'b0;
        case (kind)
            BK_SHORT, BK_PRED: begin
                hit    = flag_hit;
                uncond = (cond_in[2:0] == 3'd0);
            end
            BK_REG:  hit = zero_hit;
            default: hit = 1'b1;
        endcase
        if (valid_in) begin
            res_d.valid  = 1'b1;
            res_d.taken  = hit;
            res_d.link   = (kind == BK_CALL);
            if (kind == BK_CALL)
                res_d.annul = 1'b0;
            else if (uncond)
                res_d.annul = annul_bit;
            else
                res_d.annul = annul_bit && !hit;
            res_d.target = hit ? jump_addr : pc_in + SEQ_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign valid_out  = res_q.valid;
    assign taken_out  = res_q.taken;
    assign annul_out  = res_q.annul;
    assign link_out   = res_q.link;
    assign target_out = res_q.target;
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_in,
    input logic [1:0]    kind_in,
    input logic [3:0]    cond_in,
    input logic          annul_bit,
    input logic [AW-1:0] pc_in,
    input logic          valid_out,
    input logic          taken_out,
    input logic          annul_out,
    input logic          link_out,
    input logic [AW-1:0] target_out
);
    logic is_cond;
    assign is_cond = (kind_in == 2'd2) ||
                     (kind_in < 2'd2 && cond_in[2:0] != 3'd0);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out && !taken_out && !annul_out && !link_out); // R9
    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && kind_in == 2'd3) |=> taken_out && link_out && !annul_out); // R7
    AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && kind_in != 2'd3) |=> !link_out); // R7
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && kind_in < 2'd2 && cond_in == 4'd8) |=> taken_out && annul_out == $past(annul_bit)); // R6
    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && kind_in < 2'd2 && cond_in == 4'd0) |=> !taken_out && annul_out == $past(annul_bit)); // R6
    AST_TAKEN_NO_ANNUL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && is_cond) |=> !(taken_out && annul_out)); // R5
    AST_UNTAKEN_ANNUL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && is_cond) |=> (taken_out || annul_out == $past(annul_bit))); // R5
    AST_SEQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (taken_out || target_out == $past(pc_in) + AW'(8))); // R8
endmodule

bind branch_resolve bru_checker #(.AW(ADDR_W)) u_bru_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .kind_in    (kind_in),
    .cond_in    (cond_in),
    .annul_bit  (annul_bit),
    .pc_in      (pc_in),
    .valid_out  (valid_out),
    .taken_out  (taken_out),
    .annul_out  (annul_out),
    .link_out   (link_out),
    .target_out (target_out)
);

// File: tb/test_branch_resolve.sv
`timescale 1ns/1ps
module test_branch_resolve;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  kind_in = '0;
    logic [3:0]  cond_in = '0;
    logic [7:0]  ccr_in = '0;
    logic [63:0] src_val = '0;
    logic [29:0] disp_in = '0;
    logic        annul_bit = 1'b0;
    logic        cc_sel = 1'b0;
    logic [63:0] pc_in = '0;
    logic        valid_out, taken_out, annul_out, link_out;
    logic [63:0] target_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_resolve i_branch_resolve (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .kind_in(kind_in),
        .cond_in(cond_in), .ccr_in(ccr_in), .src_val(src_val), .disp_in(disp_in),
        .annul_bit(annul_bit), .cc_sel(cc_sel), .pc_in(pc_in),
        .valid_out(valid_out), .taken_out(taken_out), .annul_out(annul_out),
        .link_out(link_out), .target_out(target_out)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  cond;
        logic [7:0]  ccr;
        logic [63:0] rs1;
        logic [29:0] disp;
        logic        a;
        logic        sel;
        logic [63:0] pc;
        logic        taken;
        logic        annul;
        logic        link;
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] P  = 64'h0000_0000_0001_0000;
    localparam logic [63:0] P2 = 64'h0000_0000_8000_0004;
    localparam int NV = 26;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd1,  8'h04, 64'd0, 30'h10,       1'b0, 1'b0, P,  1'b1, 1'b0, 1'b0, 8'd1}, // R1 Z set
        '{2'd0, 4'd1,  8'h00, 64'd0, 30'h10,       1'b1, 1'b0, P,  1'b0, 1'b1, 1'b0, 8'd5}, // R5 untaken annul
        '{2'd0, 4'd10, 8'h00, 64'd0, 30'h20,       1'b1, 1'b0, P,  1'b1, 1'b0, 1'b0, 8'd1}, // R1 greater
        '{2'd0, 4'd3,  8'h0A, 64'd0, 30'h20,       1'b0, 1'b0, P,  1'b0, 1'b0, 1'b0, 8'd1}, // R1 N==V
        '{2'd0, 4'd12, 8'h01, 64'd0, 30'h20,       1'b1, 1'b0, P2, 1'b0, 1'b1, 1'b0, 8'd1}, // R1 carry
        '{2'd0, 4'd4,  8'h01, 64'd0, 30'h3FFFFC,   1'b0, 1'b0, P,  1'b1, 1'b0, 1'b0, 8'd3}, // R3 negative
        '{2'd0, 4'd8,  8'h00, 64'd0, 30'h100,      1'b1, 1'b0, P,  1'b1, 1'b1, 1'b0, 8'd6}, // R6 always
        '{2'd0, 4'd0,  8'hFF, 64'd0, 30'h100,      1'b1, 1'b0, P,  1'b0, 1'b1, 1'b0, 8'd6}, // R6 never a=1
        '{2'd0, 4'd0,  8'hFF, 64'd0, 30'h100,      1'b0, 1'b0, P,  1'b0, 1'b0, 1'b0, 8'd6}, // R6 never a=0
        '{2'd1, 4'd9,  8'h04, 64'd0, 30'h100,      1'b0, 1'b1, P,  1'b1, 1'b0, 1'b0, 8'd2}, // R2 high set
        '{2'd1, 4'd9,  8'h04, 64'd0, 30'h100,      1'b1, 1'b0, P,  1'b0, 1'b1, 1'b0, 8'd2}, // R2 low set
        '{2'd1, 4'd6,  8'h80, 64'd0, 30'h7FFF0,    1'b0, 1'b1, P2, 1'b1, 1'b0, 1'b0, 8'd3}, // R3 pred negative
        '{2'd1, 4'd7,  8'h20, 64'd0, 30'h40,       1'b0, 1'b0, P,  1'b0, 1'b0, 1'b0, 8'd2}, // R2 V low clear
        '{2'd1, 4'd7,  8'h20, 64'd0, 30'h40,       1'b1, 1'b1, P,  1'b1, 1'b0, 1'b0, 8'd5}, // R5 taken no annul
        '{2'd2, 4'd1,  8'h00, 64'd0, 30'h0000C001, 1'b0, 1'b0, P,  1'b1, 1'b0, 1'b0, 8'd4}, // R4 ==0 neg offset
        '{2'd2, 4'd3,  8'h00, 64'h8000_0000_0000_0000, 30'h0000_1234, 1'b0, 1'b0, P, 1'b1, 1'b0, 1'b0, 8'd4}, // R4 <0
        '{2'd2, 4'd6,  8'h00, 64'd0, 30'h0000_1234, 1'b1, 1'b0, P,  1'b0, 1'b1, 1'b0, 8'd4}, // R4 >0 false
        '{2'd2, 4'd7,  8'h00, 64'd5, 30'h0000_4003, 1'b0, 1'b0, P,  1'b1, 1'b0, 1'b0, 8'd4}, // R4 >=0
        '{2'd2, 4'd2,  8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 30'h8, 1'b0, 1'b0, P, 1'b1, 1'b0, 1'b0, 8'd4}, // R4 <=0
        '{2'd2, 4'd5,  8'h00, 64'd0, 30'h8,        1'b0, 1'b0, P,  1'b0, 1'b0, 1'b0, 8'd4}, // R4 !=0 false
        '{2'd2, 4'd4,  8'hFF, 64'd7, 30'h8,        1'b1, 1'b0, P,  1'b0, 1'b1, 1'b0, 8'd4}, // R4 reserved
        '{2'd2, 4'd9,  8'h00, 64'd0, 30'h8,        1'b0, 1'b0, P,  1'b1, 1'b0, 1'b0, 8'd4}, // R4 bit3 ignored
        '{2'd3, 4'd0,  8'h00, 64'd0, 30'h3FFFFFFF, 1'b1, 1'b0, P,  1'b1, 1'b0, 1'b1, 8'd7}, // R7 call back
        '{2'd0, 4'd14, 8'h08, 64'd0, 30'h10,       1'b0, 1'b0, P,  1'b0, 1'b0, 1'b0, 8'd8}, // R8 POS false
        '{2'd0, 4'd13, 8'h00, 64'd0, 30'h10,       1'b0, 1'b0, P,  1'b1, 1'b0, 1'b0, 8'd1}, // R1 C clear
        '{2'd0, 4'd1,  8'h40, 64'd0, 30'h10,       1'b1, 1'b1, P,  1'b0, 1'b1, 1'b0, 8'd2}  // R2 short ignores sel
    };

    function automatic logic [63:0] exp_target(vec_t v);
        logic [63:0] off;
        if (!v.taken) return v.pc + 64'd8;
        case (v.kind)
            2'd0:    off = {{40{v.disp[21]}}, v.disp[21:0], 2'b00};
            2'd1:    off = {{43{v.disp[18]}}, v.disp[18:0], 2'b00};
            2'd2:    off = {{46{v.disp[15]}}, v.disp[15:14], v.disp[13:0], 2'b00};
            default: off = {{32{v.disp[29]}}, v.disp, 2'b00};
        endcase
        return v.pc + off;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        valid_in  = vld;
        kind_in   = v.kind;
        cond_in   = v.cond;
        ccr_in    = v.ccr;
        src_val   = v.rs1;
        disp_in   = v.disp;
        annul_bit = v.a;
        cc_sel    = v.sel;
        pc_in     = v.pc;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check({valid_out, taken_out, annul_out, link_out} == 4'b0 && target_out == '0,
              "R10 reset", {60'd0, valid_out, taken_out, annul_out, link_out} | target_out, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [3:0] ef, af;
            string tag;
            v = VECS[i];
            drive(v, 1'b1);
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d flags", v.req, i);
            ef = {1'b1, v.taken, v.annul, v.link};
            af = {valid_out, taken_out, annul_out, link_out};
            check(af == ef, tag, {60'd0, af}, {60'd0, ef});
            tag = $sformatf("R%0d vec%0d target", v.taken ? v.req : 8'd8, i);
            check(target_out == exp_target(v), tag, target_out, exp_target(v));
        end

        // R9: idle cycle with a call pattern on the inputs produces nothing
        drive(VECS[22], 1'b0);
        @(negedge clk);
        check({valid_out, taken_out, annul_out, link_out} == 4'b0, "R9 idle",
              {60'd0, valid_out, taken_out, annul_out, link_out}, 64'd0);

        // R9: result stays one cycle behind the presented instruction
        drive(VECS[6], 1'b1);
        @(negedge clk);
        drive(VECS[8], 1'b1);
        check(taken_out == 1'b1 && annul_out == 1'b1, "R9 latency first",
              {62'd0, taken_out, annul_out}, 64'd3);
        @(negedge clk);
        check(taken_out == 1'b0 && annul_out == 1'b0 && valid_out, "R9 latency second",
              {62'd0, taken_out, annul_out}, 64'd0);

        // R10: reset mid-run clears a pending taken call
        drive(VECS[22], 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({valid_out, taken_out, annul_out, link_out} == 4'b0 && target_out == '0,
              "R10 reset mid-run", {60'd0, valid_out, taken_out, annul_out, link_out}, 64'd0);
        valid_in = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule